// File: doc/BRIEF.md
# Buffered Serial Transmitter

This block is the transmit half of an asynchronous serial port. Characters arrive on a one-cycle write strobe and wait in a first-in first-out store of configurable depth. A shift engine takes them one at a time and sends each as a frame: a low start bit, eight data bits with the least significant bit first, an optional parity bit and one or two high stop bits. Every bit lasts eight pulses of an external tick, and that tick runs at eight times the bit rate.

Status outputs report the store's occupancy count and whether it is empty, full or below half full. A separate flag is high when the shift engine is idle and nothing is queued. An interrupt line gives a single-cycle pulse each time the occupancy falls below half, but only while its enable input is high. Dropping the transmit enable stops the frame in progress at once, and that character is lost. Characters written while the block is disabled are kept in the store and are sent once it is enabled.

Top module: `uart_tx_fifo_top`

## Requirements
- R1: A frame is a start bit at 0, then data bits 0 to 7 in that order, then a stop bit at 1. Every bit holds `txd_o` for exactly 8 `baud_tick_i` pulses.
- R2: When `par_en_i` is 1, a parity bit follows data bit 7. With `par_odd_i`=0 it equals the XOR of the eight data bits; with `par_odd_i`=1 it is the inverse of that XOR.
- R3: When `stop2_i` is 1, a second stop bit at 1 follows the first.
- R4: Characters go out in the order they were accepted. A character written while `tx_en_i` is 0 is stored and sent after enable.
- R5: A write while `fifo_full_o` is 1 is discarded. `count_o` stays at DEPTH and the character is never sent.
- R6: One cycle after each accepted write or each start of a frame, `count_o` gives the number of stored characters. `fifo_empty_o` is high when the count is 0, `fifo_full_o` when it is DEPTH, and `below_half_o` when it is less than DEPTH/2.
- R7: `shift_empty_o` is 1 when no frame is in progress and the store is empty. It falls in the cycle after a write is accepted.
- R8: Clearing `tx_en_i` during a frame drives `txd_o` high from the next cycle. The aborted character is not sent again.
- R9: `txd_o` is 1 whenever no frame is in progress, and in every cycle that follows a cycle with `tx_en_i` at 0.
- R10: `irq_o` is high for one cycle when `below_half_o` goes from 0 to 1 while `irq_en_i` is 1. It never goes high while `irq_en_i` is 0.
- R11: A write that lands in the same cycle as the start of a frame leaves `count_o` unchanged, and the frame starts in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable; low aborts any frame in progress |
| par_en_i | input | 1 | Adds a parity bit |
| par_odd_i | input | 1 | Selects odd parity (1) or even parity (0) |
| stop2_i | input | 1 | Selects two stop bits |
| irq_en_i | input | 1 | Enables the interrupt pulse |
| baud_tick_i | input | 1 | One-cycle pulse at 8x the bit rate |
| wr_en_i | input | 1 | Write strobe for a character |
| wr_data_i | input | 8 | Character to queue |
| txd_o | output | 1 | Serial output, idles high |
| shift_empty_o | output | 1 | Shift engine idle and store empty |
| fifo_empty_o | output | 1 | Store holds no characters |
| fifo_full_o | output | 1 | Store holds DEPTH characters |
| below_half_o | output | 1 | Occupancy below DEPTH/2 |
| count_o | output | $clog2(DEPTH+1) | Current occupancy |
| irq_o | output | 1 | Interrupt pulse on falling below half |

## Verification
Two things can happen in the same clock edge: a write pushing into the store and the shift engine popping the head entry to start a frame. The bench sets this up with one character already stored while the block is disabled. It then raises the enable and a second write strobe on the same falling edge. After the next rising edge it expects the count still at one and the start bit already on the line, and the scoreboard then checks that both characters arrive in order.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned FRAME_W = DATA_W + 4;
  localparam int unsigned PHASE_W = 3;

  typedef logic [DATA_W-1:0]  char_t;
  typedef logic [FRAME_W-1:0] frame_t;

  // LSB-first frame; unused upper positions are idle level
  function automatic frame_t build_frame(char_t d, logic par_en, logic par_odd);
    logic p;
    p = (^d) ^ par_odd;
    if (par_en) build_frame = {2'b11, p, d, 1'b0};
    else        build_frame = {3'b111, d, 1'b0};
  endfunction

  function automatic logic [3:0] frame_bits(logic par_en, logic stop2);
    frame_bits = 4'(DATA_W + 2) + {3'b000, par_en} + {3'b000, stop2};
  endfunction
endpackage

// File: rtl/uart_tx_store.sv
module uart_tx_store #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 push_i,
  input  uart_tx_pkg::char_t   push_data_i,
  input  logic                 pop_i,
  output uart_tx_pkg::char_t   head_o,
  output logic [CNT_W-1:0]     count_o
);
  import uart_tx_pkg::*;

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  char_t            mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             do_push, do_pop;

  assign do_push = push_i && (count_q != FULL_CNT);
  assign do_pop  = pop_i && (count_q != '0);

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = count_q;
endmodule

// File: rtl/uart_tx_flags.sv
module uart_tx_flags #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic             irq_en_i,
  output logic             empty_o,
  output logic             full_o,
  output logic             below_half_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

  logic below_q;

  assign empty_o      = (count_i == '0);
  assign full_o       = (count_i == FULL_CNT);
  assign below_half_o = (count_i < HALF_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) below_q <= 1'b1;
    else         below_q <= below_half_o;
  end

  assign irq_o = irq_en_i && below_half_o && !below_q;
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tx_en_i,
  input  logic               par_en_i,
  input  logic               par_odd_i,
  input  logic               stop2_i,
  input  logic               baud_tick_i,
  input  logic               avail_i,
  input  uart_tx_pkg::char_t head_i,
  output logic               pop_o,
  output logic               busy_o,
  output logic               txd_o
);
  import uart_tx_pkg::*;

  localparam logic [PHASE_W-1:0] LAST_PHASE = '1;

  logic               busy_q;
  logic [PHASE_W-1:0] phase_q;
  logic [3:0]         left_q;
  frame_t             sreg_q;

  assign pop_o = !busy_q && tx_en_i && avail_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= '0;
      left_q  <= '0;
      sreg_q  <= '1;
    end else if (!tx_en_i) begin
      busy_q  <= 1'b0;  // abort immediately
      phase_q <= '0;
      sreg_q  <= '1;
    end else if (pop_o) begin
      busy_q  <= 1'b1;
      phase_q <= '0;
      left_q  <= frame_bits(par_en_i, stop2_i);
      sreg_q  <= build_frame(head_i, par_en_i, par_odd_i);
    end else if (busy_q && baud_tick_i) begin
      phase_q <= phase_q + 1'b1;
      if (phase_q == LAST_PHASE) begin
        sreg_q <= {1'b1, sreg_q[FRAME_W-1:1]};
        left_q <= left_q - 1'b1;
        if (left_q == 4'd1) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign txd_o  = busy_q ? sreg_q[0] : 1'b1;
endmodule

// File: rtl/uart_tx_fifo_top.sv
module uart_tx_fifo_top #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_en_i,
  input  logic             par_en_i,
  input  logic             par_odd_i,
  input  logic             stop2_i,
  input  logic             irq_en_i,
  input  logic             baud_tick_i,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  output logic             txd_o,
  output logic             shift_empty_o,
  output logic             fifo_empty_o,
  output logic             fifo_full_o,
  output logic             below_half_o,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  import uart_tx_pkg::*;

  char_t            head;
  logic [CNT_W-1:0] count;
  logic             pop, busy, empty;

  uart_tx_store #(.DEPTH(DEPTH)) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (wr_en_i),
    .push_data_i(wr_data_i),
    .pop_i      (pop),
    .head_o     (head),
    .count_o    (count)
  );

  uart_tx_flags #(.DEPTH(DEPTH)) i_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .count_i     (count),
    .irq_en_i    (irq_en_i),
    .empty_o     (empty),
    .full_o      (fifo_full_o),
    .below_half_o(below_half_o),
    .irq_o       (irq_o)
  );

  uart_tx_shifter i_shifter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_en_i    (tx_en_i),
    .par_en_i   (par_en_i),
    .par_odd_i  (par_odd_i),
    .stop2_i    (stop2_i),
    .baud_tick_i(baud_tick_i),
    .avail_i    (!empty),
    .head_i     (head),
    .pop_o      (pop),
    .busy_o     (busy),
    .txd_o      (txd_o)
  );

  assign fifo_empty_o  = empty;
  assign shift_empty_o = empty && !busy;
  assign count_o       = count;
endmodule

// File: rtl/uart_tx_checker.sv
module uart_tx_checker #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_en_i,
  input logic             irq_en_i,
  input logic             txd_o,
  input logic             shift_empty_o,
  input logic             fifo_empty_o,
  input logic             fifo_full_o,
  input logic [CNT_W-1:0] count_o,
  input logic             irq_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  assert_idle_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> txd_o);

  assert_quiet_line_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_empty_o |-> (txd_o && fifo_empty_o));

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o <= FULL_CNT) && (fifo_full_o == (count_o == FULL_CNT)));

  assert_count_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == $past(count_o)) || (count_o == $past(count_o) + ONE) ||
    ($past(count_o) == count_o + ONE));

  assert_irq_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_en_i);

  assert_irq_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

bind uart_tx_fifo_top uart_tx_checker #(.DEPTH(DEPTH)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tx_en_i      (tx_en_i),
  .irq_en_i     (irq_en_i),
  .txd_o        (txd_o),
  .shift_empty_o(shift_empty_o),
  .fifo_empty_o (fifo_empty_o),
  .fifo_full_o  (fifo_full_o),
  .count_o      (count_o),
  .irq_o        (irq_o)
);

// File: tb/test_uart_tx_fifo_top.sv
`timescale 1ns/1ps
module test_uart_tx_fifo_top;
  localparam int DEPTH = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 0, par_en = 0, par_odd = 0, stop2 = 0, irq_en = 0;
  logic baud_tick = 0, wr_en = 0;
  logic [7:0] wr_data = '0;
  logic txd, shift_empty, f_empty, f_full, below_half, irq;
  logic [CNT_W-1:0] count;

  int checks = 0, failures = 0, irq_pulses = 0, tick_cnt = 0;
  bit mon_on = 1'b1;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  uart_tx_fifo_top #(.DEPTH(DEPTH)) i_uart_tx_fifo_top (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .par_en_i(par_en),
    .par_odd_i(par_odd), .stop2_i(stop2), .irq_en_i(irq_en),
    .baud_tick_i(baud_tick), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .txd_o(txd), .shift_empty_o(shift_empty), .fifo_empty_o(f_empty),
    .fifo_full_o(f_full), .below_half_o(below_half), .count_o(count),
    .irq_o(irq));

  always @(negedge clk) begin
    tick_cnt  <= (tick_cnt == 3) ? 0 : tick_cnt + 1;
    baud_tick <= (tick_cnt == 3);
  end

  always @(posedge clk) if (rst_n && irq) irq_pulses++;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!baud_tick);
    end
    @(negedge clk);
  endtask

  // driver: pushes the expected character when the write should be accepted
  task automatic write_byte(logic [7:0] d, bit accept);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (accept) exp_q.push_back(d);
  endtask

  task automatic wait_drain();
    int guard = 0;
    while (!(shift_empty && exp_q.size() == 0) && guard < 20000) begin
      @(negedge clk); guard++;
    end
    repeat (40) @(negedge clk);
  endtask

  // monitor: decodes frames mid-bit and compares them against the queue
  initial begin
    logic prev = 1'b1;
    forever begin
      @(negedge clk);
      if (mon_on && rst_n && prev && !txd) begin
        logic [7:0] got = '0;
        logic [7:0] exp;
        wait_ticks(4);
        check("R1 start", txd, 0);
        for (int b = 0; b < 8; b++) begin
          wait_ticks(8);
          got[b] = txd;
        end
        if (par_en) begin
          wait_ticks(8);
          check("R2 parity", txd, (^got) ^ par_odd);
        end
        wait_ticks(8);
        check("R1 stop", txd, 1);
        if (stop2) begin
          wait_ticks(8);
          check("R3 second stop", txd, 1);
        end
        exp = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
        check("R4 data order", got, exp);
      end
      prev = txd;
    end
  end

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset txd", txd, 1);
    check("R7 reset shift_empty", shift_empty, 1);
    check("R6 reset empty", f_empty, 1);
    check("R6 reset full", f_full, 0);
    check("R6 reset below_half", below_half, 1);
    check("R6 reset count", count, 0);
    check("R10 reset irq", irq, 0);

    // stored while disabled, sent after enable
    write_byte(8'hA5, 1);
    check("R7 shift_empty clears", shift_empty, 0);
    write_byte(8'h3C, 1);
    write_byte(8'h01, 1);
    check("R6 count three", count, 3);
    repeat (50) @(negedge clk);
    check("R9 idle while disabled", txd, 1);
    tx_en = 1'b1;
    wait_drain();
    check("R4 queue drained", exp_q.size(), 0);

    par_en = 1; par_odd = 0;
    write_byte(8'h96, 1); write_byte(8'h07, 1);
    wait_drain();
    par_odd = 1;
    write_byte(8'h96, 1); write_byte(8'hF1, 1);
    wait_drain();
    par_en = 0; stop2 = 1;
    write_byte(8'h5A, 1); write_byte(8'hC3, 1);
    wait_drain();
    stop2 = 0;

    // fill to full, overflow write, drain with interrupt enabled
    tx_en = 0; irq_en = 1;
    for (int i = 0; i < DEPTH; i++) write_byte(8'(8'h10 + i), 1);
    check("R6 full flag", f_full, 1);
    check("R6 count full", count, DEPTH);
    check("R6 not below half", below_half, 0);
    write_byte(8'hEE, 0);
    check("R5 overflow discarded", count, DEPTH);
    irq_pulses = 0;
    tx_en = 1;
    wait_drain();
    check("R5 nothing extra sent", exp_q.size(), 0);
    check("R10 one pulse when enabled", irq_pulses, 1);

    tx_en = 0; irq_en = 0;
    for (int i = 0; i < DEPTH; i++) write_byte(8'(8'h40 + i), 1);
    irq_pulses = 0;
    tx_en = 1;
    wait_drain();
    check("R10 no pulse when masked", irq_pulses, 0);

    // push and frame start in the same cycle
    tx_en = 0;
    write_byte(8'h81, 1);
    @(negedge clk);
    tx_en = 1; wr_en = 1; wr_data = 8'h7E;
    @(negedge clk);
    wr_en = 0;
    exp_q.push_back(8'h7E);
    check("R11 count unchanged", count, 1);
    check("R11 start bit out", txd, 0);
    wait_drain();
    check("R11 both sent", exp_q.size(), 0);

    // abort mid-frame
    mon_on = 0;
    write_byte(8'h00, 0);
    wait_ticks(20);
    tx_en = 0;
    @(negedge clk);
    check("R8 line high after abort", txd, 1);
    check("R8 idle after abort", shift_empty, 1);
    check("R8 store empty", count, 0);
    tx_en = 1;
    begin
      int lows = 0;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        if (!txd) lows++;
      end
      check("R8 aborted char not resent", lows, 0);
    end
    mon_on = 1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule